// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block keeps one address reservation per processor in front of a small word memory that several processors share. A processor opens a reservation with a linked load, which reads a word and remembers its address. A later conditional store to that word writes memory only if the reservation is still intact, and reports 1 for success or 0 for failure. On a 0, software repeats the linked load and the conditional store until the store succeeds. That retry loop is how atomic exchange and fetch-and-increment are built on top of this block.

A reservation is lost in three ways. Another processor or an outside agent, seen on the snoop write port, may write the reserved word. The owning processor may receive a context-switch pulse. The owning processor may issue any conditional store, successful or not. Each processor issues at most one operation per cycle. Every operation is answered exactly one cycle later.

Each reservation is a two-state machine, `LINK_IDLE` and `LINK_HELD`:

- Transition *LL_TAKE* goes from `LINK_IDLE` to `LINK_HELD` on a linked load that is not cancelled in the same cycle.
- Transition *LINK_REPLACE* stays in `LINK_HELD` and takes on a new linked-load address.
- Transition *LINK_LOST* goes from `LINK_HELD` to `LINK_IDLE` on a conflicting write, a context switch, or the owner's own conditional store.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no processor holds a reservation, `rsp_valid` is 0, and every memory word reads 0.
- R2: The operation kinds are encoded as 2'b00 plain load, 2'b01 plain store, 2'b10 linked load and 2'b11 conditional store. Each valid operation gives `rsp_valid` high in the next cycle. A load or linked load returns the word as it stood before any write made in the same cycle.
- R3: A conditional store whose processor holds a reservation on the same address writes its data and returns `rsp_sc_ok` = 1.
- R4: A conditional store fails, returning 0 and leaving memory unchanged, when its processor holds no reservation or holds one on a different address.
- R5: A snoop write to a reserved address cancels that reservation. This includes a snoop write made in the same cycle as the linked load.
- R6: A plain store, or a winning conditional store, by another processor to the reserved address cancels the reservation. The owner's own plain store does not cancel it.
- R7: A context-switch pulse cancels its processor's reservation. A conditional store in the same cycle as the pulse fails.
- R8: Any conditional store, whether it succeeds or fails, consumes the issuing processor's reservation, so a second conditional store without a new linked load fails.
- R9: A new linked load replaces the processor's earlier reservation, so only the latest address can succeed.
- R10: When several conditional stores with valid reservations reach the same address in one cycle, the lowest-numbered processor succeeds and the others fail.
- R11: When writes to the same word collide in one cycle, the word keeps the data of the lowest-numbered writing processor. A processor write takes precedence over a snoop write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | NCPU | One operation request per processor |
| op_kind | input | 2*NCPU | Operation kind per processor (R2 encoding) |
| op_addr | input | AW*NCPU | Word address per processor |
| op_wdata | input | DW*NCPU | Store data per processor |
| ctx_sw | input | NCPU | Context-switch pulse per processor |
| snoop_we | input | 1 | Write by an outside agent |
| snoop_addr | input | AW | Address of the outside write |
| snoop_wdata | input | DW | Data of the outside write |
| rsp_valid | output | NCPU | Response for the previous cycle's operation |
| rsp_rdata | output | DW*NCPU | Read data of a load or linked load |
| rsp_sc_ok | output | NCPU | Conditional-store result (1 = stored) |

## Verification
The assertions assume that `op_kind` and `op_addr` carry known values whenever `op_valid` is high. They also assume that the context-switch and snoop inputs are never unknown after reset. The bench meets these assumptions by driving every input on the falling edge and by returning `op_valid`, `ctx_sw` and `snoop_we` to zero after each operation. Collisions are built on purpose by placing several requests in the same cycle. Every other scenario issues one request per cycle, so that the result expected for each response can be worked out from the requirements alone.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } op_kind_e;

    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_HELD = 1'b1
    } link_state_e;
endpackage

// File: rtl/llsc_link_fsm.sv
module llsc_link_fsm
    import llsc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          drop,
    input  logic [AW-1:0] take_addr,
    output logic          held,
    output logic [AW-1:0] link_addr
);
    link_state_e   state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // transitions: LL_TAKE, LINK_REPLACE, LINK_LOST
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            LINK_IDLE: begin
                if (take && !drop) begin
                    state_d = LINK_HELD;
                    addr_d  = take_addr;
                end
            end
            LINK_HELD: begin
                if (drop) begin
                    state_d = LINK_IDLE;
                end else if (take) begin
                    addr_d = take_addr;
                end
            end
            default: state_d = LINK_IDLE;
        endcase
    end

    assign held      = (state_q == LINK_HELD);
    assign link_addr = addr_q;

    // R9
    ll_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !drop) |=> (held && link_addr == $past(take_addr)));
endmodule

// File: rtl/llsc_arbiter.sv
module llsc_arbiter
    import llsc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCPU-1:0]   op_valid,
    input  logic [2*NCPU-1:0] op_kind,
    input  logic [AW*NCPU-1:0] op_addr,
    input  logic [NCPU-1:0]   ctx_sw,
    input  logic              snoop_we,
    input  logic [AW-1:0]     snoop_addr,
    input  logic [NCPU-1:0]   held,
    input  logic [AW*NCPU-1:0] link_addr,
    output logic [NCPU-1:0]   take,
    output logic [NCPU-1:0]   drop,
    output logic [NCPU-1:0]   sc_win,
    output logic [NCPU-1:0]   cpu_we
);
    logic [NCPU-1:0][1:0]    kind_v;
    logic [NCPU-1:0][AW-1:0] addr_v;
    logic [NCPU-1:0][AW-1:0] link_v;
    logic [NCPU-1:0][AW-1:0] watch_v;
    logic [NCPU-1:0]         is_ll, is_sc, is_st;

    assign kind_v = op_kind;
    assign addr_v = op_addr;
    assign link_v = link_addr;

    always_comb begin
        for (int i = 0; i < NCPU; i++) begin
            is_ll[i] = op_valid[i] && (kind_v[i] == OP_LL);
            is_sc[i] = op_valid[i] && (kind_v[i] == OP_SC);
            is_st[i] = op_valid[i] && (kind_v[i] == OP_STORE);
        end
    end

    // conditional-store winners, lowest index first
    always_comb begin
        sc_win = '0;
        for (int i = 0; i < NCPU; i++) begin
            sc_win[i] = is_sc[i] && held[i] && (link_v[i] == addr_v[i]) && !ctx_sw[i]
                        && !(snoop_we && snoop_addr == addr_v[i]);
            for (int j = 0; j < NCPU; j++) begin
                if (j != i && is_st[j] && addr_v[j] == addr_v[i]) sc_win[i] = 1'b0;
                if (j < i && sc_win[j] && addr_v[j] == addr_v[i]) sc_win[i] = 1'b0;
            end
        end
    end

    assign cpu_we = is_st | sc_win;
    assign take   = is_ll;

    // reservation loss per processor
    always_comb begin
        for (int i = 0; i < NCPU; i++) begin
            watch_v[i] = is_ll[i] ? addr_v[i] : link_v[i];
            drop[i]    = ctx_sw[i] || is_sc[i] || (snoop_we && snoop_addr == watch_v[i]);
            for (int j = 0; j < NCPU; j++) begin
                if (j != i && cpu_we[j] && addr_v[j] == watch_v[i]) drop[i] = 1'b1;
            end
        end
    end

    genvar gi, gj;
    generate
        for (gi = 0; gi < NCPU; gi++) begin : g_pi
            for (gj = gi + 1; gj < NCPU; gj++) begin : g_pj
                // R10
                sc_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (sc_win[gi] && sc_win[gj]) |-> (addr_v[gi] != addr_v[gj]));
            end
        end
    endgenerate
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int NCPU = 4,
    parameter int AW   = 4,
    parameter int DW   = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW*NCPU-1:0] op_addr,
    input  logic [DW*NCPU-1:0] op_wdata,
    input  logic [NCPU-1:0]    cpu_we,
    input  logic               snoop_we,
    input  logic [AW-1:0]      snoop_addr,
    input  logic [DW-1:0]      snoop_wdata,
    output logic [DW*NCPU-1:0] rd_data
);
    logic [DEPTH-1:0][DW-1:0] mem;
    logic [NCPU-1:0][AW-1:0]  addr_v;
    logic [NCPU-1:0][DW-1:0]  wdat_v;
    logic [NCPU-1:0][DW-1:0]  rd_v;

    assign addr_v = op_addr;
    assign wdat_v = op_wdata;

    // later assignments win: snoop first, then processors high to low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            if (snoop_we) mem[snoop_addr] <= snoop_wdata;
            for (int i = NCPU - 1; i >= 0; i--) begin
                if (cpu_we[i]) mem[addr_v[i]] <= wdat_v[i];
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCPU; gi++) begin : g_rd
            assign rd_v[gi] = mem[addr_v[gi]];
        end
    endgenerate
    assign rd_data = rd_v;

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!snoop_we && cpu_we == '0) |=> $stable(mem));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int AW   = 4,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCPU-1:0]    op_valid,
    input  logic [2*NCPU-1:0]  op_kind,
    input  logic [AW*NCPU-1:0] op_addr,
    input  logic [DW*NCPU-1:0] op_wdata,
    input  logic [NCPU-1:0]    ctx_sw,
    input  logic               snoop_we,
    input  logic [AW-1:0]      snoop_addr,
    input  logic [DW-1:0]      snoop_wdata,
    output logic [NCPU-1:0]    rsp_valid,
    output logic [DW*NCPU-1:0] rsp_rdata,
    output logic [NCPU-1:0]    rsp_sc_ok
);
    logic [NCPU-1:0]    take, drop, sc_win, cpu_we, held;
    logic [AW*NCPU-1:0] link_addr;
    logic [DW*NCPU-1:0] rd_data;

    genvar gi;
    generate
        for (gi = 0; gi < NCPU; gi++) begin : g_link
            llsc_link_fsm #(.AW(AW)) u_link (
                .clk       (clk),
                .rst_n     (rst_n),
                .take      (take[gi]),
                .drop      (drop[gi]),
                .take_addr (op_addr[gi*AW +: AW]),
                .held      (held[gi]),
                .link_addr (link_addr[gi*AW +: AW])
            );

            // R7
            ctx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctx_sw[gi] |=> !held[gi]);

            // R2
            sc_ok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_sc_ok[gi] |-> ($past(op_valid[gi]) && $past(op_kind[gi*2 +: 2]) == OP_SC));
        end
    endgenerate

    llsc_arbiter #(.NCPU(NCPU), .AW(AW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .op_addr    (op_addr),
        .ctx_sw     (ctx_sw),
        .snoop_we   (snoop_we),
        .snoop_addr (snoop_addr),
        .held       (held),
        .link_addr  (link_addr),
        .take       (take),
        .drop       (drop),
        .sc_win     (sc_win),
        .cpu_we     (cpu_we)
    );

    llsc_mem #(.NCPU(NCPU), .AW(AW), .DW(DW)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_addr     (op_addr),
        .op_wdata    (op_wdata),
        .cpu_we      (cpu_we),
        .snoop_we    (snoop_we),
        .snoop_addr  (snoop_addr),
        .snoop_wdata (snoop_wdata),
        .rd_data     (rd_data)
    );

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_rdata <= '0;
            rsp_sc_ok <= '0;
        end else begin
            rsp_valid <= op_valid;
            rsp_rdata <= rd_data;
            rsp_sc_ok <= sc_win;
        end
    end
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
    localparam int NCPU = 4;
    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LL = 2'b10, K_SC = 2'b11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCPU-1:0]    op_valid = '0;
    logic [2*NCPU-1:0]  op_kind = '0;
    logic [AW*NCPU-1:0] op_addr = '0;
    logic [DW*NCPU-1:0] op_wdata = '0;
    logic [NCPU-1:0]    ctx_sw = '0;
    logic               snoop_we = 1'b0;
    logic [AW-1:0]      snoop_addr = '0;
    logic [DW-1:0]      snoop_wdata = '0;
    logic [NCPU-1:0]    rsp_valid;
    logic [DW*NCPU-1:0] rsp_rdata;
    logic [NCPU-1:0]    rsp_sc_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    llsc_monitor #(.NCPU(NCPU), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .ctx_sw(ctx_sw),
        .snoop_we(snoop_we), .snoop_addr(snoop_addr), .snoop_wdata(snoop_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int c, input logic [1:0] k, input int a, input int d);
        op_valid[c]             = 1'b1;
        op_kind[c*2 +: 2]       = k;
        op_addr[c*AW +: AW]     = AW'(a);
        op_wdata[c*DW +: DW]    = DW'(d);
    endtask

    task automatic snoop(input int a, input int d);
        snoop_we    = 1'b1;
        snoop_addr  = AW'(a);
        snoop_wdata = DW'(d);
    endtask

    // inputs set at a falling edge; results visible at the next falling edge
    task automatic step();
        @(negedge clk);
        op_valid = '0;
        ctx_sw   = '0;
        snoop_we = 1'b0;
    endtask

    function automatic int rd(input int c);
        return int'(rsp_rdata[c*DW +: DW]);
    endfunction

    task automatic do_op(input int c, input logic [1:0] k, input int a, input int d);
        put(c, k, a, d);
        step();
    endtask

    task automatic expect_word(input int a, input int exp, input string req);
        do_op(0, K_LD, a, 0);
        check(rd(0) == exp, req, rd(0), exp);
    endtask

    task automatic expect_sc(input int c, input int exp, input string req);
        check(rsp_valid[c] && rsp_sc_ok[c] == exp[0], req, int'(rsp_sc_ok[c]), exp);
    endtask

    task automatic t_reset();
        check(rsp_valid == '0, "R1 valid after reset", int'(rsp_valid), 0);
        do_op(2, K_LD, 5, 0);
        check(rsp_valid[2] == 1'b1, "R2 response valid", int'(rsp_valid), 4);
        check(rd(2) == 0, "R1 word zero", rd(2), 0);
        do_op(1, K_SC, 5, 8'h5A);
        expect_sc(1, 0, "R1 no reservation after reset");
    endtask

    task automatic t_basic();
        do_op(0, K_ST, 2, 8'h11);
        do_op(0, K_LL, 2, 0);
        check(rd(0) == 8'h11, "R2 linked load data", rd(0), 8'h11);
        do_op(0, K_SC, 2, 8'h22);
        expect_sc(0, 1, "R3 sc success");
        expect_word(2, 8'h22, "R3 sc wrote");
    endtask

    task automatic t_fail_cases();
        do_op(1, K_SC, 3, 8'h55);
        expect_sc(1, 0, "R4 sc without link");
        expect_word(3, 0, "R4 memory unchanged");
        do_op(1, K_LL, 4, 0);
        do_op(1, K_SC, 5, 8'h66);
        expect_sc(1, 0, "R4 sc wrong address");
        expect_word(5, 0, "R4 wrong address unchanged");
        do_op(1, K_SC, 4, 8'h67);
        expect_sc(1, 0, "R8 link consumed by failed sc");
        do_op(1, K_LL, 4, 0);
        do_op(1, K_SC, 4, 8'h68);
        expect_sc(1, 1, "R8 first sc ok");
        do_op(1, K_SC, 4, 8'h69);
        expect_sc(1, 0, "R8 second sc fails");
        expect_word(4, 8'h68, "R8 second sc no write");
    endtask

    task automatic t_snoop();
        do_op(2, K_LL, 6, 0);
        snoop(6, 8'h77);
        step();
        do_op(2, K_SC, 6, 8'h88);
        expect_sc(2, 0, "R5 snoop clears");
        expect_word(6, 8'h77, "R5 snoop data kept");
        put(2, K_LL, 7, 0);
        snoop(7, 8'h19);
        step();
        check(rd(2) == 0, "R2 same-cycle read old", rd(2), 0);
        do_op(2, K_SC, 7, 8'h1A);
        expect_sc(2, 0, "R5 same-cycle snoop clears");
        expect_word(7, 8'h19, "R5 same-cycle word");
    endtask

    task automatic t_other_writers();
        do_op(0, K_LL, 8, 0);
        do_op(3, K_ST, 8, 8'h31);
        do_op(0, K_SC, 8, 8'h32);
        expect_sc(0, 0, "R6 other store clears");
        expect_word(8, 8'h31, "R6 other store data");
        do_op(0, K_LL, 9, 0);
        do_op(0, K_ST, 9, 8'h41);
        snoop(10, 8'hA0);
        step();
        do_op(0, K_SC, 9, 8'h42);
        expect_sc(0, 1, "R6 own store keeps link");
        expect_word(9, 8'h42, "R6 own sc data");
        do_op(0, K_LL, 15, 0);
        do_op(2, K_LL, 15, 0);
        do_op(0, K_SC, 15, 8'hF0);
        expect_sc(0, 1, "R6 first sc wins");
        do_op(2, K_SC, 15, 8'hF2);
        expect_sc(2, 0, "R6 winning sc clears other link");
        expect_word(15, 8'hF0, "R6 word after loser");
    endtask

    task automatic t_ctx();
        do_op(3, K_LL, 11, 0);
        ctx_sw[3] = 1'b1;
        step();
        do_op(3, K_SC, 11, 8'hB0);
        expect_sc(3, 0, "R7 ctx clears");
        do_op(3, K_LL, 11, 0);
        put(3, K_SC, 11, 8'hB1);
        ctx_sw[3] = 1'b1;
        step();
        expect_sc(3, 0, "R7 ctx same cycle as sc");
        expect_word(11, 0, "R7 word unchanged");
    endtask

    task automatic t_replace();
        do_op(1, K_LL, 12, 0);
        do_op(1, K_LL, 13, 0);
        do_op(1, K_SC, 12, 8'hC1);
        expect_sc(1, 0, "R9 old address fails");
        do_op(1, K_LL, 12, 0);
        do_op(1, K_LL, 13, 0);
        do_op(1, K_SC, 13, 8'hD1);
        expect_sc(1, 1, "R9 newest address wins");
    endtask

    task automatic t_race();
        put(1, K_LL, 14, 0);
        put(2, K_LL, 14, 0);
        step();
        put(2, K_SC, 14, 8'hB2);
        put(1, K_SC, 14, 8'hB1);
        step();
        expect_sc(1, 1, "R10 lower index wins");
        expect_sc(2, 0, "R10 higher index fails");
        expect_word(14, 8'hB1, "R10 winner data");
    endtask

    task automatic t_store_prio();
        put(3, K_ST, 1, 8'hC3);
        put(2, K_ST, 1, 8'hC2);
        snoop(1, 8'hCE);
        step();
        expect_word(1, 8'hC2, "R11 lowest writer kept");
    endtask

    task automatic t_retry();
        int val;
        int tries;
        bit ok;
        do_op(1, K_LL, 0, 0);
        val = rd(1);
        snoop(0, 8'h05);
        step();
        do_op(1, K_SC, 0, val + 1);
        expect_sc(1, 0, "R5 interfered increment fails");
        ok    = 1'b0;
        tries = 0;
        while (!ok && tries < 4) begin
            do_op(1, K_LL, 0, 0);
            val = rd(1);
            do_op(1, K_SC, 0, val + 1);
            ok = rsp_sc_ok[1];
            tries++;
        end
        check(ok && tries == 1, "R3 retry succeeds", tries, 1);
        expect_word(0, 8'h06, "R3 increment result");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fail_cases();
        t_snoop();
        t_other_writers();
        t_ctx();
        t_replace();
        t_race();
        t_store_prio();
        t_retry();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule